// File: doc/BRIEF.md
# DLL Bring-up and Memory Reset Sequencer

This block brings the delay-locked loops of a DDR memory interface out of reset in a fixed, timed order. One master DLL and up to four byte-lane slave DLLs each receive a phase setting, a disable control and an active-low reset control. A single start pulse launches the run. The block first drives the external memory reset pulse. It then walks the master DLL through three control steps. After that, all enabled slave lanes walk through the same three steps together, with one shared wait per step.

All phase settings come from one packed 32-bit phase word that is captured at start. The master takes a 6-bit field at bits [21:16]. The slave lanes take successive 4-bit nibbles from the bottom of the word. A bus-width flag, also captured at start, selects how many lanes take part. Every wait counts a one-microsecond tick from outside, so the wait lengths are parameters and a bench can shorten them.

Top module: `dll_bringup_seq`

## Requirements
- R1: After reset, busy and done are low and every phase output is zero. Every DLL is held with disable high and reset_n low. The memory reset output sits at its idle level, which is high.
- R2: A start seen while idle captures the phase word, the width flag and the polarity select, and raises busy on the next cycle. A start seen while busy has no effect. A change of the phase word, width flag or polarity select during a run has no effect on any output.
- R3: The memory reset output is driven to its active level for RST_US ticks, starting with the cycle after start. The active level is high when the polarity select is 1 and low when it is 0. At all other times the output holds the opposite level.
- R4: The master phase output equals bits [21:16] of the captured phase word from the cycle after start onward.
- R5: Slave lane n (n = 1..4) sits at bits [4n-1:4n-4] of the lane phase bus and at bit n-1 of the lane control buses. Its phase is bits [4n-1:4n-4] of the captured word. With the width flag at 1, lanes 1 to 4 are active. With it at 0, only lanes 1 and 2 are active. From the cycle after start, an inactive lane shows phase zero, disable high and reset_n low.
- R6: Control step one drives disable high and reset_n low for SHORT_US ticks.
- R7: Control step two drives disable low and reset_n low for LONG_US ticks.
- R8: Control step three drives disable low and reset_n high for LONG_US ticks. Those values are then held until the next run.
- R9: The steps run in this order: memory reset pulse, the three master steps, then the three steps of all active lanes together. A lane is never released from reset unless the master is already released and enabled.
- R10: A wait ends at the clock edge that samples its N-th tick. Cycles without a tick do not advance the sequence. A tick sampled on the start edge is not counted.
- R11: Busy stays high from the cycle after start until the last wait ends. Done is high for exactly that one following cycle, with busy low.
- R12: No DLL ever shows disable high together with reset_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a bring-up run (honoured only while idle) |
| phase_word | input | 32 | Packed phase settings for master and lanes |
| wide_bus | input | 1 | 1: 32-bit bus (4 lanes), 0: 16-bit bus (2 lanes) |
| rev_sel | input | 1 | 1: memory reset pulses high, 0: pulses low |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| mem_rst | output | 1 | External memory reset line |
| mst_phase | output | 6 | Master DLL phase |
| mst_dis | output | 1 | Master DLL disable |
| mst_rst_n | output | 1 | Master DLL reset, active low |
| lane_phase | output | 16 | Lane phases, 4 bits per lane, lane 1 lowest |
| lane_dis | output | 4 | Lane DLL disables, lane 1 at bit 0 |
| lane_rst_n | output | 4 | Lane DLL resets, active low, lane 1 at bit 0 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle, whatever the stimulus:
- busy and done never coincide, and done lasts one cycle and coincides with busy falling;
- no DLL is ever both disabled and released;
- a lane leaves reset only after the master is released;
- phases stay frozen during a run;
- the memory reset line stays quiet while idle;
- master controls move only on a tick edge.

The exact lengths of each step in ticks, the polarity of the reset pulse, the nibble-to-lane mapping and the lane count per width can only be shown by the bench scenarios. The bench uses a tick-indexed timeline model across several tick spacings, both widths, both polarities and mid-run restarts.

// File: rtl/dllseq_pkg.sv
package dllseq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_MEMRST,
      SQ_MST_OFF,
      SQ_MST_LOCK,
      SQ_MST_RUN,
      SQ_LN_OFF,
      SQ_LN_LOCK,
      SQ_LN_RUN
   } seq_step_e;

   typedef struct packed {
      logic dis;
      logic rst_n;
   } dll_cmd_t;

   localparam dll_cmd_t CMD_HOLD = '{dis: 1'b1, rst_n: 1'b0};

   function automatic seq_step_e step_after(input seq_step_e s);
      case (s)
         SQ_MEMRST:   return SQ_MST_OFF;
         SQ_MST_OFF:  return SQ_MST_LOCK;
         SQ_MST_LOCK: return SQ_MST_RUN;
         SQ_MST_RUN:  return SQ_LN_OFF;
         SQ_LN_OFF:   return SQ_LN_LOCK;
         SQ_LN_LOCK:  return SQ_LN_RUN;
         default:     return SQ_IDLE;
      endcase
   endfunction

   function automatic dll_cmd_t cmd_of(input seq_step_e s);
      case (s)
         SQ_MST_LOCK, SQ_LN_LOCK: return '{dis: 1'b0, rst_n: 1'b0};
         SQ_MST_RUN,  SQ_LN_RUN:  return '{dis: 1'b0, rst_n: 1'b1};
         default:                 return CMD_HOLD;
      endcase
   endfunction

   function automatic logic is_master_step(input seq_step_e s);
      return (s == SQ_MST_OFF) || (s == SQ_MST_LOCK) || (s == SQ_MST_RUN);
   endfunction

   function automatic logic is_lane_step(input seq_step_e s);
      return (s == SQ_LN_OFF) || (s == SQ_LN_LOCK) || (s == SQ_LN_RUN);
   endfunction

endpackage

// File: rtl/dllseq_wait_timer.sv
module dllseq_wait_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             expire
);

   logic [CNT_W-1:0] remain;

   // the wait ends on the edge that samples its last tick
   assign expire = tick && (remain == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= load_val;
      end else if (tick && (remain != '0)) begin
         remain <= remain - CNT_W'(1);
      end
   end

endmodule

// File: rtl/dllseq_dll_ctl.sv
module dllseq_dll_ctl
   import dllseq_pkg::*;
#(
   parameter int PH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_ph,
   input  logic [PH_W-1:0] ph_in,
   input  logic            apply,
   input  dll_cmd_t        cmd,
   output logic [PH_W-1:0] ph,
   output logic            dis,
   output logic            dll_rst_n
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= '0;
         dis       <= 1'b1;
         dll_rst_n <= 1'b0;
      end else begin
         if (load_ph) begin
            ph <= ph_in;
         end
         if (apply) begin
            dis       <= cmd.dis;
            dll_rst_n <= cmd.rst_n;
         end
      end
   end

endmodule

// File: rtl/dllseq_phase_unpack.sv
module dllseq_phase_unpack #(
   parameter int PHASE_W      = 32,
   parameter int MST_LSB      = 16,
   parameter int MST_W        = 6,
   parameter int LANE_W       = 4,
   parameter int WIDE_LANES   = 4,
   parameter int NARROW_LANES = 2
) (
   input  logic [PHASE_W-1:0]           word,
   input  logic                         wide,
   output logic [MST_W-1:0]             mst_ph,
   output logic [WIDE_LANES*LANE_W-1:0] lane_ph,
   output logic [WIDE_LANES-1:0]        lane_on
);

   if (MST_LSB + MST_W > PHASE_W) begin : g_bad_mst
      $error("master phase field lies outside the phase word");
   end
   if (WIDE_LANES * LANE_W > PHASE_W) begin : g_bad_lanes
      $error("lane nibbles do not fit the phase word");
   end
   if (NARROW_LANES > WIDE_LANES || NARROW_LANES < 1) begin : g_bad_narrow
      $error("narrow lane count out of range");
   end

   assign mst_ph = word[MST_LSB +: MST_W];

   for (genvar i = 0; i < WIDE_LANES; i++) begin : g_lane
      if (i < NARROW_LANES) begin : g_always
         assign lane_on[i] = 1'b1;
      end else begin : g_wide_only
         assign lane_on[i] = wide;
      end
      assign lane_ph[i*LANE_W +: LANE_W] =
         lane_on[i] ? word[i*LANE_W +: LANE_W] : '0;
   end

endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
   import dllseq_pkg::*;
#(
   parameter int PHASE_W      = 32,
   parameter int MST_LSB      = 16,
   parameter int MST_W        = 6,
   parameter int LANE_W       = 4,
   parameter int WIDE_LANES   = 4,
   parameter int NARROW_LANES = 2,
   parameter int RST_US       = 2,
   parameter int SHORT_US     = 2,
   parameter int LONG_US      = 22
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [PHASE_W-1:0]           phase_word,
   input  logic                         wide_bus,
   input  logic                         rev_sel,
   input  logic                         us_tick,
   output logic                         mem_rst,
   output logic [MST_W-1:0]             mst_phase,
   output logic                         mst_dis,
   output logic                         mst_rst_n,
   output logic [WIDE_LANES*LANE_W-1:0] lane_phase,
   output logic [WIDE_LANES-1:0]        lane_dis,
   output logic [WIDE_LANES-1:0]        lane_rst_n,
   output logic                         busy,
   output logic                         done
);

   localparam int MAX_US_A = (RST_US > SHORT_US) ? RST_US : SHORT_US;
   localparam int MAX_US   = (MAX_US_A > LONG_US) ? MAX_US_A : LONG_US;
   localparam int CNT_W    = $clog2(MAX_US + 1);

   if (RST_US < 1 || SHORT_US < 1 || LONG_US < 1) begin : g_bad_wait
      $error("every wait must last at least one tick");
   end

   seq_step_e             state;
   seq_step_e             nxt_state;
   logic                  start_acc;
   logic                  expire;
   logic                  adv;
   logic                  tmr_load;
   logic [CNT_W-1:0]      tmr_val;
   logic                  rev_q;
   logic                  done_q;
   logic [WIDE_LANES-1:0] lane_on_new;
   logic [WIDE_LANES-1:0] lane_on_q;
   logic [MST_W-1:0]      mst_ph_new;
   logic [WIDE_LANES*LANE_W-1:0] lane_ph_new;
   dll_cmd_t              step_cmd;
   dll_cmd_t              lane_cmd;

   function automatic logic [CNT_W-1:0] dur_of(input seq_step_e s);
      case (s)
         SQ_MEMRST:            return CNT_W'(RST_US);
         SQ_MST_OFF, SQ_LN_OFF: return CNT_W'(SHORT_US);
         default:              return CNT_W'(LONG_US);
      endcase
   endfunction

   assign start_acc = start && (state == SQ_IDLE);
   assign adv       = expire && (state != SQ_IDLE);
   assign nxt_state = step_after(state);
   assign tmr_load  = start_acc || (adv && (nxt_state != SQ_IDLE));
   assign tmr_val   = start_acc ? CNT_W'(RST_US) : dur_of(nxt_state);
   assign step_cmd  = cmd_of(nxt_state);
   assign lane_cmd  = start_acc ? CMD_HOLD : step_cmd;

   dllseq_wait_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .tick     (us_tick),
      .expire   (expire)
   );

   dllseq_phase_unpack #(
      .PHASE_W      (PHASE_W),
      .MST_LSB      (MST_LSB),
      .MST_W        (MST_W),
      .LANE_W       (LANE_W),
      .WIDE_LANES   (WIDE_LANES),
      .NARROW_LANES (NARROW_LANES)
   ) u_unpack (
      .word    (phase_word),
      .wide    (wide_bus),
      .mst_ph  (mst_ph_new),
      .lane_ph (lane_ph_new),
      .lane_on (lane_on_new)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         rev_q     <= 1'b0;
         lane_on_q <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= adv && (state == SQ_LN_RUN);
         if (start_acc) begin
            state     <= SQ_MEMRST;
            rev_q     <= rev_sel;
            lane_on_q <= lane_on_new;
         end else if (adv) begin
            state <= nxt_state;
         end
      end
   end

   dllseq_dll_ctl #(
      .PH_W (MST_W)
   ) u_master (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_ph   (start_acc),
      .ph_in     (mst_ph_new),
      .apply     (adv && is_master_step(nxt_state)),
      .cmd       (step_cmd),
      .ph        (mst_phase),
      .dis       (mst_dis),
      .dll_rst_n (mst_rst_n)
   );

   for (genvar i = 0; i < WIDE_LANES; i++) begin : g_slave
      logic apply_i;
      assign apply_i = (start_acc && !lane_on_new[i]) ||
                       (adv && is_lane_step(nxt_state) && lane_on_q[i]);

      dllseq_dll_ctl #(
         .PH_W (LANE_W)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_ph   (start_acc),
         .ph_in     (lane_ph_new[i*LANE_W +: LANE_W]),
         .apply     (apply_i),
         .cmd       (lane_cmd),
         .ph        (lane_phase[i*LANE_W +: LANE_W]),
         .dis       (lane_dis[i]),
         .dll_rst_n (lane_rst_n[i])
      );
   end

   assign mem_rst = (state == SQ_MEMRST) ? rev_q : ~rev_q;
   assign busy    = (state != SQ_IDLE);
   assign done    = done_q;

endmodule

// File: rtl/dllseq_chk.sv
module dllseq_chk #(
   parameter int MST_W  = 6,
   parameter int LANE_W = 4,
   parameter int LANES  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    us_tick,
   input logic                    busy,
   input logic                    done,
   input logic                    mem_rst,
   input logic [MST_W-1:0]        mst_phase,
   input logic                    mst_dis,
   input logic                    mst_rst_n,
   input logic [LANES*LANE_W-1:0] lane_phase,
   input logic [LANES-1:0]        lane_dis,
   input logic [LANES-1:0]        lane_rst_n
);

   a_r11_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r11_fall_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $fell(busy));

   a_r12_mst_not_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(mst_dis && mst_rst_n));

   a_r12_lane_not_both: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_dis & lane_rst_n) == '0);

   a_r9_lane_after_mst: assert property (@(posedge clk) disable iff (!rst_n)
      (|(lane_rst_n & ~$past(lane_rst_n))) |-> (mst_rst_n && !mst_dis));

   a_r2_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(mst_phase) && $stable(lane_phase)));

   a_r3_memrst_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> $stable(mem_rst));

   a_r10_mst_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({mst_dis, mst_rst_n}) |-> $past(us_tick));

endmodule

bind dll_bringup_seq dllseq_chk #(
   .MST_W  (MST_W),
   .LANE_W (LANE_W),
   .LANES  (WIDE_LANES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .us_tick    (us_tick),
   .busy       (busy),
   .done       (done),
   .mem_rst    (mem_rst),
   .mst_phase  (mst_phase),
   .mst_dis    (mst_dis),
   .mst_rst_n  (mst_rst_n),
   .lane_phase (lane_phase),
   .lane_dis   (lane_dis),
   .lane_rst_n (lane_rst_n)
);

// File: tb/test_dll_bringup_seq.sv
module test_dll_bringup_seq;

   localparam int RST_T   = 3;
   localparam int SHORT_T = 2;
   localparam int LONG_T  = 5;
   localparam int B1 = RST_T;
   localparam int B2 = B1 + SHORT_T;
   localparam int B3 = B2 + LONG_T;
   localparam int B4 = B3 + LONG_T;
   localparam int B5 = B4 + SHORT_T;
   localparam int B6 = B5 + LONG_T;
   localparam int B7 = B6 + LONG_T;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] phase_word = '0;
   logic        wide_bus = 1'b0;
   logic        rev_sel = 1'b0;
   logic        us_tick = 1'b0;
   logic        mem_rst;
   logic [5:0]  mst_phase;
   logic        mst_dis;
   logic        mst_rst_n;
   logic [15:0] lane_phase;
   logic [3:0]  lane_dis;
   logic [3:0]  lane_rst_n;
   logic        busy;
   logic        done;

   dll_bringup_seq #(
      .RST_US   (RST_T),
      .SHORT_US (SHORT_T),
      .LONG_US  (LONG_T)
   ) i_dll_bringup_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .phase_word (phase_word),
      .wide_bus   (wide_bus),
      .rev_sel    (rev_sel),
      .us_tick    (us_tick),
      .mem_rst    (mem_rst),
      .mst_phase  (mst_phase),
      .mst_dis    (mst_dis),
      .mst_rst_n  (mst_rst_n),
      .lane_phase (lane_phase),
      .lane_dis   (lane_dis),
      .lane_rst_n (lane_rst_n),
      .busy       (busy),
      .done       (done)
   );

   always #5 clk = ~clk;

   int          nvec = 0;
   int          nbad = 0;
   int          cyc = 0;
   int          tmode = 0;
   int          t = 0;
   bit          run = 1'b0;
   bit          started = 1'b0;
   bit          just_done = 1'b0;
   bit          m_rev = 1'b0;
   bit          prev_m = 1'b0;
   logic [3:0]  prev_lane = '0;
   logic [3:0]  m_mask = '0;
   logic [31:0] m_word = '0;

   task automatic check(input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %0h expected %0h (t=%0d, %0t)",
                  tag, act, exp, t, $time);
      end
   endtask

   function automatic int step_of(input int tt);
      if (tt < B1) return 1;
      if (tt < B2) return 2;
      if (tt < B3) return 3;
      if (tt < B4) return 4;
      if (tt < B5) return 5;
      if (tt < B6) return 6;
      return 7;
   endfunction

   function automatic string ctl_tag(input int s);
      if (s == 2 || s == 5) return "R6";
      if (s == 3 || s == 6) return "R7";
      return "R8";
   endfunction

   function automatic bit tick_for(input int c, input int mode);
      if (mode == 0) return 1'b1;
      if (mode == 1) return (c % 3) == 0;
      return ((c % 7) == 1) || ((c % 7) == 2) || ((c % 7) == 5);
   endfunction

   // One clock: drive inputs, wait for the next falling edge, update the
   // tick-indexed model (R9 order, R10 counting) and compare every output.
   task automatic cycle_once(input bit st);
      bit         tk;
      int         s;
      logic [1:0] exp_pair;
      logic [1:0] act_pair;
      string      tg;
      tk      = tick_for(cyc, tmode);
      start   = st;
      us_tick = tk;
      @(negedge clk);
      cyc++;
      just_done = 1'b0;
      if (rst_n) begin
         if (!run && st) begin
            run     = 1'b1;
            started = 1'b1;
            t       = 0;   // R10: tick on the start edge is not counted
            m_word  = phase_word;
            m_rev   = rev_sel;
            m_mask  = wide_bus ? 4'b1111 : 4'b0011;
         end else if (run && tk) begin
            t++;
            if (t == B7) begin
               run       = 1'b0;
               just_done = 1'b1;
               prev_m    = 1'b1;
               prev_lane = m_mask;
            end
         end
      end
      s  = run ? step_of(t) : 8;
      tg = rst_n ? "R11" : "R1";
      check(tg, 64'({busy, done}), 64'({run, just_done}));
      tg = rst_n ? "R3" : "R1";
      check(tg, 64'(mem_rst), 64'((run && s == 1) ? m_rev : !m_rev));
      tg = rst_n ? "R4" : "R1";
      check(tg, 64'(mst_phase), 64'(started ? m_word[21:16] : 6'd0));
      for (int i = 0; i < 4; i++) begin
         tg = rst_n ? "R5" : "R1";
         check(tg, 64'(lane_phase[i*4 +: 4]),
               64'((started && m_mask[i]) ? m_word[i*4 +: 4] : 4'd0));
      end
      // master controls
      if (s == 2)                exp_pair = 2'b10;
      else if (s == 3)           exp_pair = 2'b00;
      else if (s >= 4 && s <= 7) exp_pair = 2'b01;
      else                       exp_pair = prev_m ? 2'b01 : 2'b10;
      tg = !rst_n ? "R1" : (run ? ctl_tag(s) : "R8");
      check(tg, 64'({mst_dis, mst_rst_n}), 64'(exp_pair));
      // lane controls
      for (int i = 0; i < 4; i++) begin
         if (run && !m_mask[i]) begin
            exp_pair = 2'b10;
            tg = "R5";
         end else begin
            if (s == 5)      exp_pair = 2'b10;
            else if (s == 6) exp_pair = 2'b00;
            else if (s == 7) exp_pair = 2'b01;
            else             exp_pair = prev_lane[i] ? 2'b01 : 2'b10;
            tg = !rst_n ? "R1" : (run ? ctl_tag(s) : "R8");
         end
         act_pair = {lane_dis[i], lane_rst_n[i]};
         check(tg, 64'(act_pair), 64'(exp_pair));
         check("R12", 64'(act_pair == 2'b11), 64'(0));
      end
      check("R12", 64'(mst_dis && mst_rst_n), 64'(0));
   endtask

   task automatic run_one(input logic [31:0] w, input bit wd, input bit rv);
      int guard;
      phase_word = w;
      wide_bus   = wd;
      rev_sel    = rv;
      cycle_once(1'b1);
      guard = 0;
      while (run && guard < 1000) begin
         if (guard == 4) begin
            // R2: new inputs plus a second start while busy
            phase_word = ~w;
            wide_bus   = !wd;
            rev_sel    = !rv;
            cycle_once(1'b1);
            check("R2", 64'({busy, mst_phase}), 64'({1'b1, w[21:16]}));
         end else begin
            cycle_once(1'b0);
         end
         guard++;
      end
      if (run) begin
         nbad++;
         $display("FAIL R11: run did not finish, actual busy %0b expected 0", busy);
         run = 1'b0;
      end
      // idle: input changes without start touch nothing (R2)
      phase_word = w ^ 32'h00FF_FFFF;
      rev_sel    = !rv;
      repeat (3) cycle_once(1'b0);
   endtask

   initial begin
      logic [31:0] w;
      repeat (3) cycle_once(1'b0);
      rst_n = 1'b1;
      repeat (2) cycle_once(1'b0);
      for (int m = 0; m < 3; m++) begin
         tmode = m;
         for (int wd = 0; wd < 2; wd++) begin
            for (int rv = 0; rv < 2; rv++) begin
               for (int p = 0; p < 2; p++) begin
                  w = (32'(m * 8 + wd * 4 + rv * 2 + p) + 32'd1) * 32'h9E37_79B1;
                  w = w ^ 32'h0012_3456;
                  run_one(w, wd[0], rv[0]);
               end
            end
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      nbad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule